// File: doc/BRIEF.md
# Sequential power-good delay chain

This block raises four power-good flags, A to D, one after another once a hot-plug start-up has finished. A start pulse turns flag A on. Flag B follows A after a delay, C follows B, and D follows C. Each delay is measured by a tick generator whose rate is set per stage, feeding an 8-bit counter. The delay ends on the 255th tick.

When flag D turns on, the block enters its sleep state and stays there. It still responds to abort. The abort input is also the synchronous reset. It stands for a fault, an under-voltage or an over-voltage event, and it drops every flag at once. A parameter selects the polarity that the flags show at the pins.

Top module: `pg_sequencer`

## Requirements
- R1: While abort is high at a clock edge, all four flags are inactive and sleep is low from the next cycle on.
- R2: A start pulse seen while the block is idle (all flags inactive) and abort is low makes flag A active in the next cycle.
- R3: Flag B becomes active exactly 255*(PB+1) clock cycles after flag A. PB is the value on `period_b`, so the tick period is PB+1 cycles and the delay is 255 ticks.
- R4: Flag C becomes active exactly 255*(PC+1) cycles after flag B. PC is the value on `period_c`.
- R5: Flag D becomes active exactly 255*(PD+1) cycles after flag C. PD is the value on `period_d`.
- R6: `sleep` is high exactly while flag D is active, and it stays high until an abort.
- R7: A start pulse has no effect while any flag is active, including in sleep. No flag changes because of it.
- R8: Abort wins over a start in the same cycle, and over a stage advance in the same cycle. In both cases the block is idle in the next cycle.
- R9: With ACTIVE_HIGH=1 an active flag reads 1. With ACTIVE_HIGH=0 an active flag reads 0 and an inactive flag reads 1.
- R10: Flags turn on strictly in the order A, B, C, D. A later flag is never active while an earlier one is inactive.
- R11: Each delay counts from zero on entry to its stage, including after an abort and a new start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| abort | input | 1 | Synchronous reset and fault abort; clears all flags |
| start | input | 1 | Start-up complete pulse; starts the chain at A |
| period_b | input | DIV_W | Tick divider for the A to B delay |
| period_c | input | DIV_W | Tick divider for the B to C delay |
| period_d | input | DIV_W | Tick divider for the C to D delay |
| flag_a | output | 1 | Power-good flag A, polarity set by ACTIVE_HIGH |
| flag_b | output | 1 | Power-good flag B |
| flag_c | output | 1 | Power-good flag C |
| flag_d | output | 1 | Power-good flag D |
| sleep | output | 1 | High once the chain is complete |

## Verification
Two pairs of events can meet in the same cycle: abort with a start pulse, and abort with the final tick that would raise flag D. The bench raises abort together with start. It also raises abort exactly in the cycle where the model's elapsed count reaches the C to D delay. In both cases the block must be idle in the next cycle, and sleep must never be seen. A behavioural model that counts elapsed cycles against 255*(P+1) is compared on every clock with an active-high instance and with an active-low instance.

// File: rtl/pg_sequencer.sv
module pg_sequencer #(
  parameter int DIV_W       = 16,
  parameter int CNT_W       = 8,
  parameter bit ACTIVE_HIGH = 1'b1
) (
  input  logic             clk,
  input  logic             abort,
  input  logic             start,
  input  logic [DIV_W-1:0] period_b,
  input  logic [DIV_W-1:0] period_c,
  input  logic [DIV_W-1:0] period_d,
  output logic             flag_a,
  output logic             flag_b,
  output logic             flag_c,
  output logic             flag_d,
  output logic             sleep
);
  localparam int NFLAG = 4;
  localparam logic [CNT_W-1:0] LAST_TICK = CNT_W'((2**CNT_W) - 2);
  localparam logic [2:0] ST_IDLE  = 3'd0;
  localparam logic [2:0] ST_SLEEP = 3'd4;

  logic [2:0]       stg;
  logic [DIV_W-1:0] div;
  logic [CNT_W-1:0] cnt;
  logic [DIV_W-1:0] per;
  logic             timing;
  logic             tick;
  logic             advance;
  logic [NFLAG-1:0] act;
  logic [NFLAG-1:0] pin;

  always_comb begin
    case (stg)
      3'd1:    per = period_b;
      3'd2:    per = period_c;
      default: per = period_d;
    endcase
  end

  assign timing  = (stg != ST_IDLE) && (stg != ST_SLEEP);
  assign tick    = timing && (div >= per);
  assign advance = tick && (cnt == LAST_TICK);

  always_ff @(posedge clk) begin
    if (abort) begin
      stg <= ST_IDLE;
      div <= '0;
      cnt <= '0;
    end else if (stg == ST_IDLE) begin
      div <= '0;
      cnt <= '0;
      if (start) stg <= 3'd1;
    end else if (advance) begin
      stg <= stg + 3'd1;
      div <= '0;
      cnt <= '0;
    end else if (tick) begin
      div <= '0;
      cnt <= cnt + 1'b1;
    end else if (timing) begin
      div <= div + 1'b1;
    end
  end

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    assign act[i] = (stg > 3'(i));
    if (ACTIVE_HIGH) begin : g_hi
      assign pin[i] = act[i];
    end else begin : g_lo
      assign pin[i] = ~act[i];
    end
  end

  assign flag_a = pin[0];
  assign flag_b = pin[1];
  assign flag_c = pin[2];
  assign flag_d = pin[3];
  assign sleep  = (stg == ST_SLEEP);
endmodule

// File: rtl/pg_sequencer_chk.sv
module pg_sequencer_chk #(
  parameter bit ACTIVE_HIGH = 1'b1
) (
  input logic clk,
  input logic abort,
  input logic start,
  input logic flag_a,
  input logic flag_b,
  input logic flag_c,
  input logic flag_d,
  input logic sleep
);
  logic a, b, c, d;
  assign a = ACTIVE_HIGH ? flag_a : ~flag_a;
  assign b = ACTIVE_HIGH ? flag_b : ~flag_b;
  assign c = ACTIVE_HIGH ? flag_c : ~flag_c;
  assign d = ACTIVE_HIGH ? flag_d : ~flag_d;

  p_abort_clears_r1: assert property (@(posedge clk)
    abort |=> (!a && !b && !c && !d && !sleep));

  p_start_sets_a_r2: assert property (@(posedge clk) disable iff (abort)
    (!a && start) |=> a);

  p_sleep_is_d_r6: assert property (@(posedge clk) disable iff (abort)
    sleep == d);

  p_start_ignored_r7: assert property (@(posedge clk) disable iff (abort)
    (a && start) |=> (a && $stable(b) && $stable(c)));

  p_order_b_r10: assert property (@(posedge clk) disable iff (abort) b |-> a);
  p_order_c_r10: assert property (@(posedge clk) disable iff (abort) c |-> b);
  p_order_d_r10: assert property (@(posedge clk) disable iff (abort) d |-> c);

  p_no_drop_r10: assert property (@(posedge clk) disable iff (abort)
    a |=> a);
endmodule

bind pg_sequencer pg_sequencer_chk #(.ACTIVE_HIGH(ACTIVE_HIGH)) u_chk (
  .clk(clk), .abort(abort), .start(start),
  .flag_a(flag_a), .flag_b(flag_b), .flag_c(flag_c), .flag_d(flag_d),
  .sleep(sleep)
);

// File: tb/pg_sequencer_tb.sv
`timescale 1ns/1ps
module pg_sequencer_tb;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic abort = 1'b1;
  logic start = 1'b0;
  logic [15:0] pb = 16'd2, pc = 16'd0, pd = 16'd1;
  logic ha, hb, hc, hd, hs;
  logic la, lb, lc, ld, ls;

  pg_sequencer #(.ACTIVE_HIGH(1'b1)) u_dut (
    .clk(clk), .abort(abort), .start(start),
    .period_b(pb), .period_c(pc), .period_d(pd),
    .flag_a(ha), .flag_b(hb), .flag_c(hc), .flag_d(hd), .sleep(hs));

  pg_sequencer #(.ACTIVE_HIGH(1'b0)) u_dut_n (
    .clk(clk), .abort(abort), .start(start),
    .period_b(pb), .period_c(pc), .period_d(pd),
    .flag_a(la), .flag_b(lb), .flag_c(lc), .flag_d(ld), .sleep(ls));

  int checks = 0, errors = 0, cyc = 0;
  int m_stg = 0, m_el = 0;
  bit chk_on = 1'b0;
  bit saw_sleep = 1'b0;

  function automatic int dly(int s);
    case (s)
      1: return 255 * (int'(pb) + 1);
      2: return 255 * (int'(pc) + 1);
      default: return 255 * (int'(pd) + 1);
    endcase
  endfunction

  always @(posedge clk) begin
    if (abort) begin
      m_stg = 0; m_el = 0;
    end else if (m_stg == 0) begin
      if (start) begin m_stg = 1; m_el = 0; end
    end else if (m_stg < 4) begin
      m_el++;
      if (m_el == dly(m_stg)) begin m_stg++; m_el = 0; end
    end
  end

  task automatic check(string tag, logic got, logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%0b exp=%0b cycle=%0d", tag, got, exp, cyc);
    end
  endtask

  always @(negedge clk) if (chk_on) begin
    check("R2 flag_a", ha, m_stg >= 1);
    check("R3 flag_b", hb, m_stg >= 2);
    check("R4 flag_c", hc, m_stg >= 3);
    check("R5 flag_d", hd, m_stg >= 4);
    check("R6 sleep",  hs, m_stg == 4);
    check("R9 low flag_a", la, !(m_stg >= 1));
    check("R9 low flag_b", lb, !(m_stg >= 2));
    check("R9 low flag_c", lc, !(m_stg >= 3));
    check("R9 low flag_d", ld, !(m_stg >= 4));
    check("R9 low sleep",  ls, m_stg == 4);
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 200000) begin
      errors++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic pulse_start();
    start = 1'b1; @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_stage(int s);
    while (m_stg != s) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk_on = 1'b1;
    // R1: reset state
    check("R1 reset flag_a", ha, 1'b0);
    check("R1 reset sleep", hs, 1'b0);
    abort = 1'b0;
    @(negedge clk);

    // R2..R6: full chain with periods 2,0,1
    pulse_start();
    wait_stage(2);
    repeat (40) @(negedge clk);
    pulse_start();                 // R7: ignored while running
    wait_stage(4);
    repeat (30) @(negedge clk);
    pulse_start();                 // R7: ignored in sleep
    repeat (10) @(negedge clk);
    check("R6 sleep held", hs, 1'b1);

    // R8: abort and start in the same cycle
    abort = 1'b1; start = 1'b1;
    @(negedge clk);
    abort = 1'b0; start = 1'b0;
    check("R8 abort beats start", ha, 1'b0);
    check("R1 sleep cleared", hs, 1'b0);
    repeat (5) @(negedge clk);

    // R11: new periods, abort mid-stage then restart from zero
    pb = 16'd0; pc = 16'd3; pd = 16'd0;
    pulse_start();
    repeat (100) @(negedge clk);
    abort = 1'b1; @(negedge clk); abort = 1'b0;
    check("R11 aborted mid B delay", ha, 1'b0);
    pulse_start();
    wait_stage(3);

    // R8: abort on the cycle of the final tick to D
    while (m_el != dly(3) - 1) @(negedge clk);
    abort = 1'b1;
    @(negedge clk);
    abort = 1'b0;
    check("R8 abort beats advance flag_d", hd, 1'b0);
    check("R8 abort beats advance sleep", hs, 1'b0);
    repeat (20) @(negedge clk);
    check("R8 stays idle", ha, 1'b0);

    // R3..R5 with fastest ticks
    pb = 16'd0; pc = 16'd0; pd = 16'd0;
    pulse_start();
    wait_stage(4);
    repeat (5) @(negedge clk);
    check("R5 sleep reached", hs, 1'b1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule